// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block turns one vectorised load or store into a stream of effective addresses, one per element, in strictly ascending element order. On a start strobe it captures the addressing configuration (a 2-bit mode code, a signed 16-bit immediate, the access size in bytes, the vector length and the sub-vector length) and then offers one address per cycle on a valid/ready handshake. The element count is the vector length times the sub-vector length. A scalar access is simply the count of one and takes the same path.

Three address formulas are supported:
- **Unit stride**: a scalar base plus the immediate plus the access size times the element number.
- **Strided**: a scalar base plus the immediate times the element number, with the immediate acting as the stride.
- **Indexed**: a full 64-bit scalar base plus a per-element index read at a narrowed element width.

When the address register is itself a vector, the per-element base value is supplied on a side input and the immediate is always applied as a stride. Unit stride does not apply in that case.

Per-element base values and the packed index stream live outside the block. The block presents the current element number and the index word number it needs, and takes the matching 64-bit values back in the same cycle.

Top module: `vec_agu`

## Requirements
- R1: After reset, `valid_o`, `done_o` and `illegal_o` are low.
- R2: A legal start with a nonzero count issues exactly `vl_i*subvl_i` addresses. `elem_o` runs 0, 1, 2 … in order, one step per accepted address, and the case VL=1, SUBVL=1 issues a single address.
- R3: In the immediate form with a scalar address register and mode code 0, element i gets address base + sext(imm) + size*i.
- R4: In the immediate form with a scalar address register and mode code 1, element i gets address base + sext(imm)*i.
- R5: In the immediate form with a vector address register (mode 0 or 1), element i gets address vbase_i + sext(imm)*i. Here vbase_i is the value presented for element `elem_o`, and the access size is not used.
- R6: In indexed mode, element i gets address base + zext(index element i), and the mode code and the vector-register flag are ignored.
  - Index width codes are 0=64, 1=32, 2=16 and 3=8 bits.
  - Element i starts at byte offset i*width/8 of the packed index stream.
  - `idx_word_o` gives that offset divided by 8.
  - Byte k of the returned word occupies bits 8k+7:8k.
- R7: A start in the immediate form with mode code 2 or 3 raises `illegal_o` for exactly the next cycle. It issues no address and no `done_o`.
- R8: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `elem_o` and `addr_o` hold (given stable side inputs).
- R9: `done_o` is high for exactly one cycle, in the cycle after the last address is accepted, and `valid_o` is low then.
- R10: A start with a zero element count raises `done_o` in the next cycle and issues no address.
- R11: All address arithmetic wraps modulo 2^64.
- R12: A start strobe while addresses are still being issued is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| mode_i | input | 2 | 0 unit stride, 1 strided, 2/3 reserved |
| indexed_i | input | 1 | Register+register (indexed) form |
| ra_vec_i | input | 1 | Address register is a vector |
| imm_i | input | 16 | Signed immediate |
| size_i | input | 4 | Access size in bytes |
| vl_i | input | 7 | Vector length |
| subvl_i | input | 3 | Sub-vector length |
| idx_ew_i | input | 2 | Index element width code |
| base_i | input | 64 | Scalar base register value |
| vbase_i | input | 64 | Base value for element `elem_o` (vector address register) |
| idx_word_i | input | 64 | Index stream word at `idx_word_o` |
| ready_i | input | 1 | Consumer accepts address |
| idx_word_o | output | 10 | Index stream word number required |
| addr_o | output | 64 | Effective address |
| elem_o | output | 10 | Current element number |
| valid_o | output | 1 | Address valid |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| illegal_o | output | 1 | One-cycle reserved-mode pulse |

## Verification
The bench uses the default parameters: 7-bit vector length, 3-bit sub-vector length and 4-bit access size. These allow element counts up to 889 and ten-bit index word numbers.

Runs of up to ten elements are used. With those lengths:
- Every index width crosses a 64-bit word boundary.
- The 8-bit width packs several elements into one word.
- Sub-vector lengths other than one multiply the count.

Negative immediates and bases near the top and bottom of the address space exercise wrap-around. Back-pressure patterns and a start pulse injected mid-run exercise the stall and ignore rules.

// File: rtl/vec_agu_pkg.sv
package vec_agu_pkg;
  localparam int unsigned WORD_W = 64;

  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_RSV2   = 2'd2,
    AM_RSV3   = 2'd3
  } amode_e;

  // log2 of index element size in bytes: code 0=64b .. 3=8b
  function automatic logic [1:0] ew_shift(input logic [1:0] ew);
    return 2'd3 - ew;
  endfunction
endpackage

// File: rtl/vec_agu_ctrl.sv
module vec_agu_ctrl #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             illegal_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic             step_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] elem_o,
  output logic             done_o,
  output logic             illegal_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q, n_q;
  logic             done_q, ill_q;

  assign load_o    = start_i && (st_q == ST_IDLE);
  assign valid_o   = (st_q == ST_RUN);
  assign step_o    = valid_o && ready_i;
  assign elem_o    = cnt_q;
  assign done_o    = done_q;
  assign illegal_o = ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      n_q    <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (illegal_i)      ill_q  <= 1'b1;
          else if (n_i == '0) done_q <= 1'b1;
          else begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
            n_q   <= n_i;
          end
        end
        ST_RUN: if (ready_i) begin
          if (cnt_q == n_q - 1'b1) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_agu_stride.sv
module vec_agu_stride #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] init_i,
  input  logic [ADDR_W-1:0] inc_i,
  output logic [ADDR_W-1:0] off_o
);
  logic [ADDR_W-1:0] off_q, inc_q;

  // running offset replaces a per-element multiply
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      inc_q <= '0;
    end else if (load_i) begin
      off_q <= init_i;
      inc_q <= inc_i;
    end else if (step_i) begin
      off_q <= off_q + inc_q;
    end
  end

  assign off_o = off_q;
endmodule

// File: rtl/vec_agu_idx.sv
module vec_agu_idx
  import vec_agu_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic [CNT_W-1:0]  elem_i,
  input  logic [1:0]        ew_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  word_addr_o,
  output logic [WORD_W-1:0] val_o
);
  logic [CNT_W+2:0]  byte_off;
  logic [2:0]        lane;
  logic [WORD_W-1:0] shifted;

  assign byte_off    = {3'b000, elem_i} << ew_shift(ew_i);
  assign word_addr_o = byte_off[CNT_W+2:3];
  assign lane        = byte_off[2:0];
  assign shifted     = word_i >> {lane, 3'b000};

  always_comb begin
    unique case (ew_i)
      2'd0:    val_o = shifted;
      2'd1:    val_o = {32'b0, shifted[31:0]};
      2'd2:    val_o = {48'b0, shifted[15:0]};
      default: val_o = {56'b0, shifted[7:0]};
    endcase
  end
endmodule

// File: rtl/vec_agu.sv
module vec_agu
  import vec_agu_pkg::*;
#(
  parameter int unsigned VL_W    = 7,
  parameter int unsigned SUBVL_W = 3,
  parameter int unsigned SIZE_W  = 4,
  parameter int unsigned IMM_W   = 16,
  localparam int unsigned CNT_W  = VL_W + SUBVL_W,
  localparam int unsigned ADDR_W = WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic               indexed_i,
  input  logic               ra_vec_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [VL_W-1:0]    vl_i,
  input  logic [SUBVL_W-1:0] subvl_i,
  input  logic [1:0]         idx_ew_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  vbase_i,
  input  logic [WORD_W-1:0]  idx_word_i,
  input  logic               ready_i,
  output logic [CNT_W-1:0]   idx_word_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [CNT_W-1:0]   elem_o,
  output logic               valid_o,
  output logic               done_o,
  output logic               illegal_o
);
  logic [CNT_W-1:0]  n_w;
  logic              illegal_w, unit_w, load, step;
  logic [ADDR_W-1:0] imm_x, init_w, inc_w, off, idx_val;
  logic [ADDR_W-1:0] base_q;
  logic              indexed_q, ra_vec_q;
  logic [1:0]        ew_q;

  assign n_w       = CNT_W'(vl_i) * CNT_W'(subvl_i);
  assign illegal_w = !indexed_i && mode_i[1];
  assign unit_w    = !indexed_i && !ra_vec_i && (amode_e'(mode_i) == AM_UNIT);
  assign imm_x     = {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign init_w    = unit_w ? imm_x : '0;
  assign inc_w     = unit_w ? ADDR_W'(size_i) : imm_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      indexed_q <= 1'b0;
      ra_vec_q  <= 1'b0;
      ew_q      <= '0;
    end else if (load) begin
      base_q    <= base_i;
      indexed_q <= indexed_i;
      ra_vec_q  <= ra_vec_i;
      ew_q      <= idx_ew_i;
    end
  end

  vec_agu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .illegal_i (illegal_w),
    .n_i       (n_w),
    .ready_i   (ready_i),
    .load_o    (load),
    .step_o    (step),
    .valid_o   (valid_o),
    .elem_o    (elem_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );

  vec_agu_stride #(.ADDR_W(ADDR_W)) u_stride (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .init_i (init_w),
    .inc_i  (inc_w),
    .off_o  (off)
  );

  vec_agu_idx #(.CNT_W(CNT_W)) u_idx (
    .elem_i      (elem_o),
    .ew_i        (ew_q),
    .word_i      (idx_word_i),
    .word_addr_o (idx_word_o),
    .val_o       (idx_val)
  );

  always_comb begin
    if (indexed_q)     addr_o = base_q + idx_val;
    else if (ra_vec_q) addr_o = vbase_i + off;
    else               addr_o = base_q + off;
  end
endmodule

// File: rtl/vec_agu_chk.sv
module vec_agu_chk #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_i,
  input logic              valid_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic [CNT_W-1:0]  elem_o,
  input logic [ADDR_W-1:0] addr_o
);
  AST_FIRST_ELEM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (elem_o == '0));  // R2
  AST_ELEM_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i) |=> (done_o || (valid_o && elem_o == $past(elem_o) + 1'b1)));  // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(elem_o)));  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);  // R9
  AST_DONE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);  // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!valid_o && !done_o));  // R7
  AST_RUN_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && start_i && !ready_i) |=> (valid_o && $stable(elem_o)));  // R12
endmodule

bind vec_agu vec_agu_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ready_i   (ready_i),
  .valid_o   (valid_o),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .elem_o    (elem_o),
  .addr_o    (addr_o)
);

// File: tb/tb_vec_agu.sv
module tb_vec_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        indexed_i = 1'b0;
  logic        ra_vec_i = 1'b0;
  logic [15:0] imm_i = '0;
  logic [3:0]  size_i = '0;
  logic [6:0]  vl_i = '0;
  logic [2:0]  subvl_i = '0;
  logic [1:0]  idx_ew_i = '0;
  logic [63:0] base_i = '0;
  logic [63:0] vbase_i, idx_word_i;
  logic        ready_i = 1'b0;
  logic [9:0]  idx_word_o, elem_o;
  logic [63:0] addr_o;
  logic        valid_o, done_o, illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  function automatic logic [7:0] idx_byte(input int b);
    return 8'((b * 37 + 11) ^ (b >> 3));
  endfunction

  function automatic logic [63:0] idx_word_f(input logic [9:0] w);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = idx_byte(int'(w) * 8 + k);
    return r;
  endfunction

  function automatic logic [63:0] vbase_f(input logic [9:0] e);
    return 64'hFFFF_FFFF_FFFF_FF00 + 64'(e) * 64'h0000_0001_0000_0030;
  endfunction

  function automatic logic [63:0] idx_elem(input logic [1:0] ew, input int i);
    logic [63:0] r;
    int wb;
    r  = '0;
    wb = 8 >> ew;
    for (int k = 0; k < wb; k++) r[k*8 +: 8] = idx_byte(i * wb + k);
    return r;
  endfunction

  function automatic logic [63:0] exp_addr(input logic ix, input logic rv, input logic [1:0] md,
                                           input logic [15:0] imm, input logic [3:0] sz,
                                           input logic [1:0] ew, input logic [63:0] base,
                                           input int i);
    logic [63:0] sx;
    sx = {{48{imm[15]}}, imm};
    if (ix)           return base + idx_elem(ew, i);
    else if (rv)      return vbase_f(10'(i)) + sx * 64'(i);
    else if (md == 0) return base + sx + 64'(sz) * 64'(i);
    else              return base + sx * 64'(i);
  endfunction

  assign idx_word_i = idx_word_f(idx_word_o);
  assign vbase_i    = vbase_f(elem_o);

  vec_agu dut (
    .clk_i, .rst_ni, .start_i, .mode_i, .indexed_i, .ra_vec_i, .imm_i, .size_i,
    .vl_i, .subvl_i, .idx_ew_i, .base_i, .vbase_i, .idx_word_i, .ready_i,
    .idx_word_o, .addr_o, .elem_o, .valid_o, .done_o, .illegal_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_seq(input logic ix, input logic rv, input logic [1:0] md,
                         input logic [15:0] imm, input logic [3:0] sz, input logic [1:0] ew,
                         input logic [63:0] base, input logic [6:0] vl, input logic [2:0] svl,
                         input bit stall, input bit poke, input string req);
    int n, k, cyc;
    bit prev_stall, r;
    logic [9:0]  p_elem;
    logic [63:0] p_addr;
    n = int'(vl) * int'(svl);
    @(negedge clk_i);
    indexed_i = ix; ra_vec_i = rv; mode_i = md; imm_i = imm; size_i = sz;
    idx_ew_i = ew; base_i = base; vl_i = vl; subvl_i = svl; ready_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    base_i = ~base;  // captured value must be used
    k = 0; cyc = 0; prev_stall = 1'b0; p_elem = '0; p_addr = '0;
    while (k < n && cyc < n * 4 + 20) begin
      r = stall ? ((cyc % 3) != 1) : 1'b1;
      if (poke && cyc == 0) begin
        r = 1'b0;
        start_i = 1'b1; imm_i = imm + 16'd77; mode_i = 2'd1; vl_i = 7'd1;  // R12 injected start
      end
      chk(valid_o === 1'b1 && elem_o == 10'(k), req, "valid/element order (R2)",
          {valid_o, 53'b0, elem_o}, {1'b1, 53'b0, 10'(k)});
      if (prev_stall)
        chk(elem_o == p_elem && addr_o == p_addr, "R8", "hold under stall", addr_o, p_addr);
      if (r) begin
        chk(addr_o == exp_addr(ix, rv, md, imm, sz, ew, base, k), req, "address",
            addr_o, exp_addr(ix, rv, md, imm, sz, ew, base, k));
        k++;
      end
      prev_stall = !r; p_elem = elem_o; p_addr = addr_o;
      ready_i = r;
      @(negedge clk_i);
      start_i = 1'b0;
      cyc++;
    end
    ready_i = 1'b0;
    chk(k == n, req, "element count (R2)", 64'(k), 64'(n));
    chk(done_o === 1'b1 && valid_o === 1'b0, "R9", "done after last", {done_o, valid_o}, 2'b10);
    @(negedge clk_i);
    chk(done_o === 1'b0 && valid_o === 1'b0, "R9", "done single cycle", {done_o, valid_o}, 2'b00);
  endtask

  task automatic t_reserved(input logic [1:0] md);
    @(negedge clk_i);
    indexed_i = 1'b0; ra_vec_i = 1'b0; mode_i = md; vl_i = 7'd4; subvl_i = 3'd1;
    start_i = 1'b1; ready_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(illegal_o === 1'b1 && valid_o === 1'b0 && done_o === 1'b0, "R7", "illegal pulse",
        {illegal_o, valid_o, done_o}, 3'b100);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i);
      chk(illegal_o === 1'b0 && valid_o === 1'b0 && done_o === 1'b0, "R7", "quiet after illegal",
          {illegal_o, valid_o, done_o}, 3'b000);
    end
    ready_i = 1'b0;
  endtask

  task automatic t_zero(input logic [6:0] vl, input logic [2:0] svl);
    @(negedge clk_i);
    indexed_i = 1'b0; ra_vec_i = 1'b0; mode_i = 2'd0; vl_i = vl; subvl_i = svl;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o === 1'b1 && valid_o === 1'b0, "R10", "zero count done", {done_o, valid_o}, 2'b10);
    @(negedge clk_i);
    chk(done_o === 1'b0 && valid_o === 1'b0, "R10", "zero count quiet", {done_o, valid_o}, 2'b00);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      summary();
    end
  end

  initial begin
    #1;
    chk(valid_o === 1'b0 && done_o === 1'b0 && illegal_o === 1'b0, "R1", "reset outputs",
        {valid_o, done_o, illegal_o}, 3'b000);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(valid_o === 1'b0 && done_o === 1'b0 && illegal_o === 1'b0, "R1", "after reset release",
        {valid_o, done_o, illegal_o}, 3'b000);
    // R2 R3 scalar single element
    run_seq(0, 0, 2'd0, 16'd40, 4'd8, 2'd0, 64'h1000, 7'd1, 3'd1, 0, 0, "R2");
    // R3 unit stride with subvl, stalls
    run_seq(0, 0, 2'd0, 16'hFFF0, 4'd8, 2'd0, 64'h0000_2000_0000_0000, 7'd5, 3'd2, 1, 0, "R3");
    // R11 unit stride wrapping past top
    run_seq(0, 0, 2'd0, 16'd0, 4'd8, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 7'd4, 3'd1, 0, 0, "R11");
    // R4 negative stride wrapping below zero
    run_seq(0, 0, 2'd1, 16'hFFFD, 4'd4, 2'd0, 64'h2, 7'd4, 3'd1, 0, 0, "R4");
    run_seq(0, 0, 2'd1, 16'd96, 4'd2, 2'd0, 64'h8000, 7'd3, 3'd3, 1, 0, "R4");
    // R5 vector base, size ignored
    run_seq(0, 1, 2'd0, 16'd24, 4'd8, 2'd0, 64'h0, 7'd6, 3'd1, 0, 0, "R5");
    run_seq(0, 1, 2'd1, 16'hFFF8, 4'd1, 2'd0, 64'h0, 7'd3, 3'd2, 1, 0, "R5");
    // R6 indexed, each width, mode and vector flag ignored
    run_seq(1, 0, 2'd3, 16'd0, 4'd8, 2'd0, 64'h4000, 7'd3, 3'd1, 0, 0, "R6");
    run_seq(1, 1, 2'd2, 16'd0, 4'd4, 2'd1, 64'hFFFF_FFFF_FFFF_0000, 7'd5, 3'd1, 1, 0, "R6");
    run_seq(1, 0, 2'd0, 16'd0, 4'd2, 2'd2, 64'h7000, 7'd9, 3'd1, 0, 0, "R6");
    run_seq(1, 0, 2'd1, 16'd0, 4'd1, 2'd3, 64'h9000, 7'd5, 3'd2, 1, 0, "R6");
    // R7 reserved codes
    t_reserved(2'd2);
    t_reserved(2'd3);
    // R10 zero count
    t_zero(7'd0, 3'd3);
    t_zero(7'd5, 3'd0);
    // R12 start during run ignored
    run_seq(0, 0, 2'd0, 16'd4, 4'd4, 2'd0, 64'h5000, 7'd3, 3'd1, 0, 1, "R12");
    summary();
  end
endmodule